// File: doc/BRIEF.md
# Port Function Control Register with Edge-Selectable NMI

This block is an 8-bit control register that sits next to an I/O port. It decides, pin by pin, whether a port pin behaves as ordinary I/O or is taken over by another function. Two pins can become active-low external interrupt request inputs. Two other pins can become the bus-release handshake, with a request input and an acknowledge output. The bus-release pair only takes effect when the chip runs in an expanded bus mode. One register bit chooses which edge of the nonmaskable interrupt pin raises a request. That pin is first passed through a synchronizer, and the detector then emits a single-cycle pulse for each qualifying edge.

The CPU writes the register and reads it back. Reset and hardware standby both load the register with its initial value. Software standby freezes the register, so its contents survive that state. The port's data path stays readable at all times: the raw pin levels remain visible to the CPU even on pins whose drivers the register has switched off.

Top module: `pctl_top`

## Requirements
- R1: A synchronous reset, or `hw_stby` high at a clock edge, loads the register with 0x87. `hw_stby` wins over a write in the same cycle. `cpu_rdata` always shows the register contents.
- R2: While `sw_stby` is high, writes are ignored and the register keeps its value.
- R3: Bit 7 is reserved. It always reads as 1, whatever value was written to it.
- R4: Bits 6 to 0 read back the value last written. Bits 2 to 0 are plain storage with reset value 1.
- R5: When bit 6 is set, pin 6 has its driver off (`pin_oe[6]`=0) and `irq1_n` follows `pin_in[6]`. When bit 6 is clear, pin 6 follows `ddr[6]`/`dout[6]` and `irq1_n` is 1.
- R6: Bit 5 controls pin 5 and `irq0_n` in the same way.
- R7: `port_rd` equals `pin_in` on every pin, whatever pin functions are selected.
- R8: When bit 3 is set and `op_mode` is 1, 2, 3 or 4, pin 3 has its driver off and `breq_n` follows `pin_in[3]`, while pin 2 is driven (`pin_oe[2]`=1, `pin_out[2]`=`bus_ack_n`). In any other mode, or when bit 3 is clear, pins 3 and 2 follow `ddr`/`dout` and `breq_n` is 1.
- R9: `nmi_pin` passes through two synchronizer flops. `nmi_req` is a one-cycle pulse for a falling edge when bit 4 is 0 and for a rising edge when bit 4 is 1. A level change present at clock edge k produces a pulse that is visible between edge k+1 and edge k+2. The synchronizer clears on reset.
- R10: Changing bit 4 while the synchronized NMI level is steady produces no pulse.
- R11: Bit 4 has no effect on any pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby; reloads the register |
| sw_stby | input | 1 | Software standby; freezes the register |
| op_mode | input | 3 | Operating mode; 1 to 4 are expanded modes |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read data |
| pin_in | input | 8 | Pin levels |
| ddr | input | 8 | Data-direction settings (1 = output) |
| dout | input | 8 | Output-data settings |
| pin_oe | output | 8 | Pin driver enables |
| pin_out | output | 8 | Pin driven values |
| port_rd | output | 8 | Pin readback toward the data register |
| nmi_pin | input | 1 | Asynchronous nonmaskable interrupt pin |
| bus_ack_n | input | 1 | Bus acknowledge from the arbiter, driven onto pin 2 |
| irq0_n | output | 1 | Interrupt request 0 level, active low |
| irq1_n | output | 1 | Interrupt request 1 level, active low |
| breq_n | output | 1 | Bus request level, active low |
| nmi_req | output | 1 | Single-cycle NMI request pulse |

## Verification
Two functions can land in the same cycle. In one case, a write flips the edge-select bit at the same edge at which a synchronized NMI transition reaches the detector. In the other, a write coincides with hardware standby. The stimulus produces both collisions, first deliberately and then through long pseudo-random runs in which writes, standby and NMI toggles overlap. A behavioural model in the bench keeps a queue of sampled NMI levels and applies the register value after the edge. Each clock it is compared with every output, so any disagreement over which select value applies, or over which source wins the register, is reported.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int          CTL_W   = 8;
    localparam logic [7:0]  CTL_RST = 8'h87;

    typedef struct packed {
        logic       rsv_one;
        logic       irq1_en;
        logic       irq0_en;
        logic       nmi_rise;
        logic       brel_en;
        logic [2:0] spare;
    } ctl_t;

    typedef struct packed {
        logic breq_n;
        logic irq1_n;
        logic irq0_n;
    } req_t;

    function automatic logic is_expanded(input logic [2:0] mode);
        return (mode >= 3'd1) && (mode <= 3'd4);
    endfunction

    function automatic ctl_t fold_write(input logic [7:0] wd);
        return ctl_t'({1'b1, wd[CTL_W-2:0]});
    endfunction

endpackage

// File: rtl/pctl_reg.sv
module pctl_reg
    import pctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_stby,
    input  logic       sw_stby,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic [7:0] rdata
);

    ctl_t q;

    always_ff @(posedge clk) begin
        if (rst || hw_stby) begin
            q <= ctl_t'(CTL_RST);
        end else if (wr_en && !sw_stby) begin
            q <= fold_write(wdata);
        end
    end

    assign ctl   = q;
    assign rdata = q;

    // R1
    hw_load_chk: assert property (@(posedge clk) disable iff (rst)
        hw_stby |=> (q == ctl_t'(CTL_RST)));

    // R2
    sw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_stby && !hw_stby) |=> $stable(q));

    // R3
    rsv_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wdata[7]) |=> q.rsv_one);

endmodule

// File: rtl/pctl_nmi_det.sv
module pctl_nmi_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_sel,
    output logic req
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign cur = sync_q[STAGES-1];
    assign req = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req || $changed(rise_sel));

endmodule

// File: rtl/pctl_pinmux.sv
module pctl_pinmux
    import pctl_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int IRQ0_PIN = 5,
    parameter int IRQ1_PIN = 6,
    parameter int BREQ_PIN = 3,
    parameter int BACK_PIN = 2
) (
    input  ctl_t              ctl,
    input  logic              expanded,
    input  logic              bus_ack_n,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] ddr,
    input  logic [PORT_W-1:0] dout,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output req_t              req
);

    logic bus_act;
    assign bus_act = ctl.brel_en & expanded;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        logic oe_b;
        logic out_b;
        always_comb begin
            oe_b  = ddr[i];
            out_b = dout[i];
            if (i == IRQ1_PIN && ctl.irq1_en) oe_b = 1'b0;
            if (i == IRQ0_PIN && ctl.irq0_en) oe_b = 1'b0;
            if (i == BREQ_PIN && bus_act)     oe_b = 1'b0;
            if (i == BACK_PIN && bus_act) begin
                oe_b  = 1'b1;
                out_b = bus_ack_n;
            end
        end
        assign pin_oe[i]  = oe_b;
        assign pin_out[i] = out_b;
    end

    always_comb begin
        req.irq1_n = ctl.irq1_en ? pin_in[IRQ1_PIN] : 1'b1;
        req.irq0_n = ctl.irq0_en ? pin_in[IRQ0_PIN] : 1'b1;
        req.breq_n = bus_act     ? pin_in[BREQ_PIN] : 1'b1;
    end

endmodule

// File: rtl/pctl_top.sv
module pctl_top
    import pctl_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int IRQ0_PIN    = 5,
    parameter int IRQ1_PIN    = 6,
    parameter int BREQ_PIN    = 3,
    parameter int BACK_PIN    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [2:0]        op_mode,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] ddr,
    input  logic [PORT_W-1:0] dout,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] port_rd,
    input  logic              nmi_pin,
    input  logic              bus_ack_n,
    output logic              irq0_n,
    output logic              irq1_n,
    output logic              breq_n,
    output logic              nmi_req
);

    ctl_t ctl;
    req_t req;
    logic expanded;

    assign expanded = is_expanded(op_mode);

    pctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (cpu_wr),
        .wdata   (cpu_wdata),
        .ctl     (ctl),
        .rdata   (cpu_rdata)
    );

    pctl_nmi_det #(.STAGES(SYNC_STAGES)) u_nmi (
        .clk      (clk),
        .rst      (rst),
        .pin      (nmi_pin),
        .rise_sel (ctl.nmi_rise),
        .req      (nmi_req)
    );

    pctl_pinmux #(
        .PORT_W   (PORT_W),
        .IRQ0_PIN (IRQ0_PIN),
        .IRQ1_PIN (IRQ1_PIN),
        .BREQ_PIN (BREQ_PIN),
        .BACK_PIN (BACK_PIN)
    ) u_mux (
        .ctl       (ctl),
        .expanded  (expanded),
        .bus_ack_n (bus_ack_n),
        .pin_in    (pin_in),
        .ddr       (ddr),
        .dout      (dout),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .req       (req)
    );

    assign irq0_n  = req.irq0_n;
    assign irq1_n  = req.irq1_n;
    assign breq_n  = req.breq_n;
    assign port_rd = pin_in;

    // R8
    single_chip_breq_chk: assert property (@(posedge clk) disable iff (rst)
        !expanded |-> breq_n);

    // R5
    irq1_drv_off_chk: assert property (@(posedge clk) disable iff (rst)
        !irq1_n |-> cpu_rdata[6]);

endmodule

// File: tb/pctl_top_bench.sv
module pctl_top_bench;

    logic       clk = 1'b0;
    logic       rst, hw_stby, sw_stby, cpu_wr, nmi_pin, bus_ack_n;
    logic [2:0] op_mode;
    logic [7:0] cpu_wdata, cpu_rdata, pin_in, ddr, dout, pin_oe, pin_out, port_rd;
    logic       irq0_n, irq1_n, breq_n, nmi_req;

    always #10 clk = ~clk;

    pctl_top u_pctl_top (
        .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .op_mode(op_mode), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .pin_in(pin_in), .ddr(ddr), .dout(dout),
        .pin_oe(pin_oe), .pin_out(pin_out), .port_rd(port_rd),
        .nmi_pin(nmi_pin), .bus_ack_n(bus_ack_n), .irq0_n(irq0_n),
        .irq1_n(irq1_n), .breq_n(breq_n), .nmi_req(nmi_req)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural reference
    logic [7:0] m_reg;
    bit         nq[$];

    always @(posedge clk) begin
        if (rst) begin
            m_reg = 8'h87;
            nq = {1'b0, 1'b0, 1'b0};
        end else begin
            if (hw_stby)                m_reg = 8'h87;
            else if (cpu_wr && !sw_stby) m_reg = cpu_wdata | 8'h80;
            nq.push_back(nmi_pin);
            while (nq.size() > 3) void'(nq.pop_front());
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [7:0] e_oe, e_out;
        logic       bus_act, e_nmi;
        bit         nw, od;
        bus_act = m_reg[3] && (op_mode >= 3'd1) && (op_mode <= 3'd4);
        e_oe  = ddr;
        e_out = dout;
        if (m_reg[6]) e_oe[6] = 1'b0;
        if (m_reg[5]) e_oe[5] = 1'b0;
        if (bus_act) begin
            e_oe[3]  = 1'b0;
            e_oe[2]  = 1'b1;
            e_out[2] = bus_ack_n;
        end
        nw = nq[1];
        od = nq[0];
        e_nmi = m_reg[4] ? (nw && !od) : (!nw && od);
        cmp("R1 R2 R3 R4 rdata", cpu_rdata, m_reg);
        cmp("R5 R6 R8 R11 pin_oe", pin_oe, e_oe);
        cmp("R8 R11 pin_out", pin_out, e_out);
        cmp("R7 port_rd", port_rd, pin_in);
        cmp("R5 irq1_n", irq1_n, m_reg[6] ? pin_in[6] : 1'b1);
        cmp("R6 irq0_n", irq0_n, m_reg[5] ? pin_in[5] : 1'b1);
        cmp("R8 breq_n", breq_n, bus_act ? pin_in[3] : 1'b1);
        cmp("R9 R10 nmi_req", nmi_req, e_nmi);
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [7:0] d);
        cpu_wr = 1'b1; cpu_wdata = d;
        step();
        cpu_wr = 1'b0;
    endtask

    bit [31:0] lf = 32'h1357_9bdf;
    task automatic adv();
        lf ^= lf << 13;
        lf ^= lf >> 17;
        lf ^= lf << 5;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst = 1'b1; hw_stby = 1'b0; sw_stby = 1'b0; op_mode = 3'd0;
        cpu_wr = 1'b0; cpu_wdata = 8'h00; nmi_pin = 1'b0; bus_ack_n = 1'b1;
        pin_in = 8'hA5; ddr = 8'hFF; dout = 8'h3C;
        @(posedge clk);
        repeat (2) step();
        rst = 1'b0;
        step();
        // R3 reserved bit, R4 storage
        wr(8'h00); step();
        wr(8'h7F); step();
        // R5 R6 interrupt takeover
        wr(8'h60); pin_in = 8'h9F; step(); pin_in = 8'h00; step();
        // R2 software standby freezes
        sw_stby = 1'b1; wr(8'h11); step(); sw_stby = 1'b0; step();
        // R1 hardware standby beats a write
        hw_stby = 1'b1; wr(8'h00); hw_stby = 1'b0; step();
        // R8 bus release across modes
        wr(8'h08); bus_ack_n = 1'b0; pin_in = 8'hF7;
        for (int m = 0; m < 8; m++) begin
            op_mode = 3'(m); step();
        end
        // R9 falling edge (bit 4 clear)
        wr(8'h07); nmi_pin = 1'b1; repeat (4) step();
        nmi_pin = 1'b0; repeat (4) step();
        // R9 rising edge
        wr(8'h17); nmi_pin = 1'b1; repeat (4) step();
        // R10 flip select with steady pin
        wr(8'h07); step(); wr(8'h17); step();
        // select change colliding with a synchronized transition
        nmi_pin = 1'b0; step(); wr(8'h07); repeat (3) step();
        // R11 bit 4 toggling with pins steady
        wr(8'h10); step(); wr(8'h00); step();
        // pseudo-random overlap
        for (int k = 0; k < 3000; k++) begin
            adv();
            pin_in    = lf[7:0];
            ddr       = lf[15:8];
            dout      = lf[23:16];
            op_mode   = lf[26:24];
            bus_ack_n = lf[27];
            if (lf[28] && lf[29]) nmi_pin = ~nmi_pin;
            adv();
            cpu_wr    = lf[0] & lf[1];
            cpu_wdata = lf[15:8];
            sw_stby   = (lf[20:18] == 3'd0);
            hw_stby   = (lf[25:21] == 5'd0);
            step();
        end
        cpu_wr = 1'b0; sw_stby = 1'b0; hw_stby = 1'b0;
        step();
        summary();
    end

endmodule